// File: doc/BRIEF.md
# Two-Cycle Ternary Bit-Manipulation Unit

This execution unit performs bit-manipulation operations that need up to three register operands: conditional move, conditional mix, rotate left and right, and funnel shift left and right. Each operation is split over two clock cycles. The first cycle works on operands A and B and leaves a partial result in one internal stage register. The second cycle combines that partial result with operand C, or with operand A again for rotates, and with operand B, to form the final word.

The issuing pipeline raises `start_i` with an operation code and the three operands. In the cycle the unit accepts the request it raises `busy_o`, so the issuer stalls and keeps the operands on the ports for one more cycle. In that following cycle `valid_o` pulses and `result_o` carries the answer. A single right-shift structure serves both cycles: left shifts are made by reversing the word before and after the shift. The funnel-shift amounts 0 and 32, where the 32-complement of the amount would be a full-word shift, are handled explicitly.

Top module: `trn_bitop_unit`

## Requirements
- R1: A request is accepted when `start_i` is high and no operation is in its second cycle. `busy_o` is high in that cycle. `valid_o` is high for exactly one cycle, the next one, and `result_o` is valid then. The operands must be held stable through both cycles.
- R2: A `start_i` that arrives in the second cycle of an operation is ignored: `busy_o` stays low, the result in flight still follows the operation code latched at acceptance, and no `valid_o` follows in the next cycle.
- R3: Operation code 0 (conditional move) returns A when B is nonzero and C when B is zero.
- R4: Operation code 1 (conditional mix) returns (A AND B) OR (C AND NOT B).
- R5: Operation code 3 rotates A right by B[4:0]. Operation code 2 rotates A left by B[4:0]. Bits B[31:5] have no effect.
- R6: A rotate by an amount of 0 returns A unchanged.
- R7: Operation code 5 (funnel right), with k = B[5:0]: for k < 32 it returns the low word of the 64-bit value {C,A} shifted right by k. For k >= 32 it returns the low word of {A,C} shifted right by k-32.
- R8: Operation code 4 (funnel left), with k = B[5:0]: for k < 32 it returns the high word of {A,C} shifted left by k. For k >= 32 it returns the high word of {C,A} shifted left by k-32.
- R9: For both funnel shifts, k = 0 returns A and k = 32 returns C. Bits B[31:6] have no effect.
- R10: Operation codes 6 and 7 complete in two cycles like any other code and return 0.
- R11: After reset, `valid_o` and `busy_o` are low and `result_o` is 0 while no request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B (condition, mask or amount) |
| opc_i | input | 32 | Operand C |
| result_o | output | 32 | Result, valid while `valid_o` is high, 0 otherwise |
| valid_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Stall request in the cycle a request is accepted |

## Verification
The bench targets the amounts at which a complement shift degenerates. If a funnel shift at k = 0 or k = 32 did not mask the full-word complement term, the result would come out as A or C ORed with garbage from the other operand. If a rotate at amount 0 were wrongly masked, it would return the right-shifted half alone. Funnel amounts just above 32 catch a design that swaps the operand roles in the wrong direction, and amounts with high bits of B set catch a design that decodes more of B than it should. A request held high into the second cycle catches a unit that would either start a second operation or let the new operation code corrupt the result in flight.

// File: rtl/trn_bitop_pkg.sv
package trn_bitop_pkg;

    typedef enum logic [2:0] {
        OP_CMOV = 3'd0,
        OP_CMIX = 3'd1,
        OP_ROL  = 3'd2,
        OP_ROR  = 3'd3,
        OP_FSL  = 3'd4,
        OP_FSR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } bitop_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        bitop_e op;
    } seq_t;

endpackage

// File: rtl/trn_bitop_shifter.sv
module trn_bitop_shifter #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    input  logic                     left_i,
    output logic [WIDTH-1:0]         data_o
);
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] fwd;
    logic [WIDTH-1:0] shr;
    logic [WIDTH-1:0] rev_out;

    // Left shifts reuse the right shifter by reversing in and out.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]  = data_i[WIDTH-1-i];
        assign rev_out[i] = shr[WIDTH-1-i];
    end

    assign fwd    = left_i ? rev_in : data_i;
    assign shr    = fwd >> amt_i;
    assign data_o = left_i ? rev_out : shr;
endmodule

// File: rtl/trn_bitop_seq.sv
module trn_bitop_seq
    import trn_bitop_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   start_i,
    input  bitop_e op_i,
    output logic   accept_o,
    output logic   second_o,
    output bitop_e op_o
);
    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        accept_o = start_i && (seq_q.phase == PH_IDLE);
        if (accept_o) begin
            seq_d.phase = PH_SECOND;
            seq_d.op    = op_i;
        end else begin
            seq_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{phase: PH_IDLE, op: OP_CMOV};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign second_o = (seq_q.phase == PH_SECOND);
    assign op_o     = seq_q.op;
endmodule

// File: rtl/trn_bitop_unit.sv
module trn_bitop_unit
    import trn_bitop_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [WIDTH-1:0] opc_i,
    output logic [WIDTH-1:0] result_o,
    output logic             valid_o,
    output logic             busy_o
);
    localparam int SHW = $clog2(WIDTH);

    logic           accept;
    logic           second;
    bitop_e         op_q;
    bitop_e         op_in;
    bitop_e         cur_op;

    logic [SHW-1:0] amt;
    logic [SHW-1:0] cmp;
    logic           amt_zero;
    logic           fsel;

    logic [WIDTH-1:0] sh_src;
    logic [SHW-1:0]   sh_amt;
    logic             sh_left;
    logic             sh_kill;
    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] sh_val;

    logic [WIDTH-1:0] stage_d, stage_q;
    logic [WIDTH-1:0] result;

    assign op_in = bitop_e'(op_i);

    trn_bitop_seq i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .op_i     (op_in),
        .accept_o (accept),
        .second_o (second),
        .op_o     (op_q)
    );

    assign cur_op   = second ? op_q : op_in;
    assign amt      = opb_i[SHW-1:0];
    assign cmp      = -amt;
    assign amt_zero = (amt == '0);
    assign fsel     = opb_i[SHW];

    // Shift control for both cycles; sh_kill zeroes a full-word complement shift.
    always_comb begin
        sh_src  = opa_i;
        sh_amt  = amt;
        sh_left = 1'b0;
        sh_kill = 1'b0;
        if (!second) begin
            case (cur_op)
                OP_ROL: sh_left = 1'b1;
                OP_FSL: begin
                    if (fsel) begin
                        sh_amt  = cmp;
                        sh_kill = amt_zero;
                    end else begin
                        sh_left = 1'b1;
                    end
                end
                OP_FSR: begin
                    if (fsel) begin
                        sh_left = 1'b1;
                        sh_amt  = cmp;
                        sh_kill = amt_zero;
                    end
                end
                default: ;
            endcase
        end else begin
            sh_src = ((cur_op == OP_ROL) || (cur_op == OP_ROR)) ? opa_i : opc_i;
            case (cur_op)
                OP_ROL: sh_amt = cmp;
                OP_ROR: begin
                    sh_left = 1'b1;
                    sh_amt  = cmp;
                end
                OP_FSL: begin
                    if (fsel) begin
                        sh_left = 1'b1;
                    end else begin
                        sh_amt  = cmp;
                        sh_kill = amt_zero;
                    end
                end
                OP_FSR: begin
                    if (!fsel) begin
                        sh_left = 1'b1;
                        sh_amt  = cmp;
                        sh_kill = amt_zero;
                    end
                end
                default: ;
            endcase
        end
    end

    trn_bitop_shifter #(.WIDTH(WIDTH)) i_shifter (
        .data_i (sh_src),
        .amt_i  (sh_amt),
        .left_i (sh_left),
        .data_o (sh_out)
    );

    assign sh_val = sh_kill ? '0 : sh_out;

    always_comb begin
        stage_d = stage_q;
        result  = '0;
        if (accept) begin
            case (op_in)
                OP_CMOV: stage_d = opa_i;
                OP_CMIX: stage_d = opa_i & opb_i;
                OP_ROL, OP_ROR, OP_FSL, OP_FSR: stage_d = sh_val;
                default: stage_d = '0;
            endcase
        end
        if (second) begin
            case (op_q)
                OP_CMOV: result = (opb_i != '0) ? stage_q : opc_i;
                OP_CMIX: result = stage_q | (opc_i & ~opb_i);
                OP_ROL, OP_ROR, OP_FSL, OP_FSR: result = stage_q | sh_val;
                default: result = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_o = result;
    assign valid_o  = second;
    assign busy_o   = accept;
endmodule

// File: rtl/trn_bitop_unit_chk.sv
module trn_bitop_unit_chk
    import trn_bitop_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0] opc_i,
    input logic [WIDTH-1:0] result_o,
    input logic             valid_o,
    input logic             busy_o
);
    localparam int SHW = $clog2(WIDTH);

    assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> valid_o);

    assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    assert_busy_needs_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> start_i);

    assert_no_accept_second_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !busy_o);

    assert_valid_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(busy_o));

    assert_cmov_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) == 3'd0 && $stable(opa_i) && opb_i != '0)
        |-> result_o == opa_i);

    assert_cmix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) == 3'd1 && $stable(opa_i) && $stable(opb_i))
        |-> result_o == ((opa_i & opb_i) | (opc_i & ~opb_i)));

    assert_funnel_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ($past(op_i) == 3'd4 || $past(op_i) == 3'd5)
         && $stable(opa_i) && $stable(opb_i) && opb_i[SHW:0] == '0)
        |-> result_o == opa_i);

    assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(op_i) >= 3'd6) |-> result_o == '0);
endmodule

bind trn_bitop_unit trn_bitop_unit_chk #(.WIDTH(WIDTH)) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .opc_i    (opc_i),
    .result_o (result_o),
    .valid_o  (valid_o),
    .busy_o   (busy_o)
);

// File: tb/test_trn_bitop_unit.sv
module test_trn_bitop_unit;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0, opb = '0, opc = '0;
    logic [31:0] result;
    logic        valid, busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trn_bitop_unit i_trn_bitop_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .opc_i(opc),
        .result_o(result), .valid_o(valid), .busy_o(busy)
    );

    // {op, A, B, C}
    localparam logic [98:0] VEC [NV] = '{
        {3'd0, 32'hDEADBEEF, 32'h00000100, 32'h01234567},  // R3 B nonzero
        {3'd0, 32'hDEADBEEF, 32'h00000000, 32'h01234567},  // R3 B zero
        {3'd1, 32'hF0F0AAAA, 32'hFF00FF00, 32'h12345678},  // R4
        {3'd1, 32'hFFFFFFFF, 32'h00000000, 32'hA5A5A5A5},  // R4
        {3'd3, 32'h80000001, 32'h00000001, 32'h0},         // R5
        {3'd2, 32'h80000001, 32'hFFFFFFE3, 32'h0},         // R5 high B bits
        {3'd3, 32'hCAFEF00D, 32'h0000001F, 32'h0},         // R5
        {3'd5, 32'h89ABCDEF, 32'h0000000C, 32'h76543210},  // R7 k<32
        {3'd5, 32'h89ABCDEF, 32'h00000021, 32'h76543210},  // R7 k=33
        {3'd5, 32'h89ABCDEF, 32'h0000003F, 32'h76543210},  // R7 k=63
        {3'd4, 32'h89ABCDEF, 32'h00000001, 32'h76543210},  // R8 k<32
        {3'd4, 32'h89ABCDEF, 32'h00000028, 32'h76543210},  // R8 k=40
        {3'd4, 32'h89ABCDEF, 32'h0000001F, 32'h76543210},  // R8 k=31
        {3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF}   // R10
    };

    function automatic logic [31:0] model(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c);
        logic [63:0] w;
        int k;
        k = int'(b[5:0]);
        case (o)
            3'd0: return (b != 0) ? a : c;
            3'd1: return (a & b) | (c & ~b);
            3'd2: begin w = {a, a} << b[4:0]; return w[63:32]; end
            3'd3: begin w = {a, a} >> b[4:0]; return w[31:0]; end
            3'd4: begin
                w = (k < 32) ? ({a, c} << k) : ({c, a} << (k - 32));
                return w[63:32];
            end
            3'd5: begin
                w = (k < 32) ? ({c, a} >> k) : ({a, c} >> (k - 32));
                return w[31:0];
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4: return "R8";
            3'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [2:0] o, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                          logic [31:0] exp, string tag);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b; opc = c;
        #1 chk({tag, " R1 busy"}, {31'b0, busy}, 32'd1);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1 valid"}, {31'b0, valid}, 32'd1);
        chk({tag, " result"}, result, exp);
        @(negedge clk);
        chk({tag, " R1 pulse end"}, {31'b0, valid}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", {31'b0, valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid", {31'b0, valid}, 32'd0);
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 result", result, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  o;
            logic [31:0] a, b, c;
            {o, a, b, c} = VEC[i];
            run_op(o, a, b, c, model(o, a, b, c), req_of(o));
        end

        // Directed corner cases
        run_op(3'd3, 32'h12345678, 32'h00000008, 32'h0, 32'h78123456, "R5 ror8");
        run_op(3'd3, 32'h12345678, 32'h00000000, 32'h0, 32'h12345678, "R6 ror0");
        run_op(3'd2, 32'h12345678, 32'h00000020, 32'h0, 32'h12345678, "R6 rol0");
        run_op(3'd5, 32'h12345678, 32'h00000004, 32'hABCDEF01, 32'h11234567, "R7 fsr4");
        run_op(3'd5, 32'h12345678, 32'hFFFFFFC0, 32'hABCDEF01, 32'h12345678, "R9 fsr0");
        run_op(3'd5, 32'h12345678, 32'h00000020, 32'hABCDEF01, 32'hABCDEF01, "R9 fsr32");
        run_op(3'd4, 32'h12345678, 32'h00000000, 32'hABCDEF01, 32'h12345678, "R9 fsl0");
        run_op(3'd4, 32'h12345678, 32'h00000020, 32'hABCDEF01, 32'hABCDEF01, "R9 fsl32");
        run_op(3'd4, 32'h12345678, 32'hFFFFFFC4, 32'hABCDEF01, 32'h2345678A, "R9 fsl4 high B");
        run_op(3'd6, 32'h12345678, 32'h1, 32'h1, 32'h0, "R10 code6");

        // R2: request held into second cycle with another code
        @(negedge clk);
        start = 1'b1; op = 3'd3; opa = 32'h12345678; opb = 32'h4; opc = 32'hFFFFFFFF;
        @(negedge clk);
        op = 3'd1;
        #1 chk("R2 busy low in second", {31'b0, busy}, 32'd0);
        chk("R2 result keeps latched op", result, 32'h81234567);
        @(negedge clk);
        start = 1'b0;
        chk("R2 no extra valid", {31'b0, valid}, 32'd0);
        chk("R2 result idle", result, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule